// File: doc/BRIEF.md
# Windowed Byte FIFO Pair with Count-Commit Access

This block holds two byte queues between a host bus and a serial engine: a receive queue that the serial side fills and the host drains, and a transmit queue that the host fills and the serial side drains. The host never pushes or pops one byte at a time through a data port. On receive it reads bytes straight out of a mapped window, where window position k is the k-th oldest unread byte, and then writes a single count that frees that many bytes. On transmit it writes bytes into a mapped window, where window position k is the k-th free slot after the committed tail, and then writes a single count that hands those bytes to the serial side in order.

The host bus is byte-addressed with a 12-bit address and 32-bit data. A window access moves one byte in data bits [7:0]. A read returns its data on `bus_rdata` in the clock cycle after `bus_rd`. In every other cycle `bus_rdata` is zero. Both queues are `DEPTH` bytes deep; `DEPTH` must be a power of two. The default is 1024. Fill counts appear in 10-bit fields. A count that does not fit in 10 bits reads as 1023.

Top module: `wf_window_fifo`

## Requirements
- R1: After synchronous reset both queues are empty, `tx_avail`, `tx_data_vld` and `rx_overrun` are low and `bus_rdata` is zero. Reading address 0x000 or 0x804 then returns zero.
- R2: Each cycle with `rx_in_vld` high and a receive queue that is not full appends `rx_in_byte` to the receive queue. A read of address 0x000 returns the receive count with count bits [7:0] in data bits [31:24] and count bits [9:8] in data bits [7:6]; all other bits are zero.
- R3: A read of address 0x004+k, for k from 0 to 1019, returns the k-th oldest receive byte (k=0 is the oldest) in `bus_rdata[7:0]` one cycle later, with the upper bits zero. When k is not below the receive count, the read returns zero. The read does not change the queue.
- R4: A write of N in data bits [9:0] to address 0x800 discards the N oldest receive bytes. An N larger than the receive count is clamped to the count.
- R5: When `rx_in_vld` is high while the receive queue holds `DEPTH` bytes, the byte is dropped and `rx_overrun` is high for exactly the next cycle. This holds even if an acknowledge is written in the same cycle.
- R6: A write of address 0x400+k with a byte in data bits [7:0] places the byte in the k-th slot after the committed transmit tail. The write is ignored when k is not below the free space (`DEPTH` minus the transmit count), and it then leaves all committed data unchanged.
- R7: A write of N in data bits [9:0] to address 0x804 appends window slots 0 to N-1, in order, to the transmit queue and advances the write pointer by N. An N larger than the free space is clamped to the free space. Slots written beyond the commit stay staged and move down by N.
- R8: A read of address 0x804 returns the transmit write pointer (modulo `DEPTH`) in data bits [9:0] and the transmit count in bits [25:16]; all other bits are zero.
- R9: `tx_avail` is high exactly when the transmit count is nonzero. `tx_pop` with a nonempty queue removes the oldest byte and shows it on `tx_data` with `tx_data_vld` high in the next cycle. `tx_pop` on an empty queue is ignored.
- R10: Pointers wrap modulo `DEPTH`, so byte order is preserved in both queues across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after bus_rd |
| rx_in_vld | input | 1 | Serial side offers a received byte |
| rx_in_byte | input | 8 | Received byte |
| rx_overrun | output | 1 | One-cycle pulse: a received byte was dropped |
| tx_pop | input | 1 | Serial side takes the oldest transmit byte |
| tx_data | output | 8 | Popped transmit byte |
| tx_data_vld | output | 1 | tx_data holds a popped byte this cycle |
| tx_avail | output | 1 | Transmit queue is not empty |

## Verification
The bench builds the block with `DEPTH` = 512. At that depth the receive count passes 255, so the upper status field at bits [7:6] takes the values 01 and 10. Filling either queue completely takes only a few hundred cycles, which brings the overrun, the clamping of acknowledge and commit counts, an ignored window write at zero free space and repeated pointer wraps within reach. A randomized phase then mixes pushes, pops, window accesses and count writes in the same cycles against the queue model.

// File: rtl/wf_pkg.sv
package wf_pkg;

  localparam logic [11:0] A_STATUS = 12'h000;
  localparam logic [11:0] A_RXWIN  = 12'h004;
  localparam logic [11:0] A_TXWIN  = 12'h400;
  localparam logic [11:0] A_RXACK  = 12'h800;
  localparam logic [11:0] A_TXCTL  = 12'h804;

  typedef enum logic [1:0] {SEL_NONE, SEL_REG, SEL_RXWIN} rsel_t;

  // Fill counts are reported in 10-bit fields; larger values saturate.
  function automatic logic [9:0] fld10(input logic [31:0] v);
    return (v > 32'd1023) ? 10'd1023 : v[9:0];
  endfunction

endpackage

// File: rtl/wf_ram.sv
module wf_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/wf_rx_side.sv
module wf_rx_side #(
  parameter int DEPTH = 1024,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [7:0]    in_byte,
  output logic          overrun,
  input  logic          ack_en,
  input  logic [9:0]    ack_n,
  input  logic          rd_en,
  input  logic [9:0]    rd_off,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q, ack_amt;
  logic          full, push_ok, hit, hit_q;
  logic [7:0]    ram_q;

  assign full    = (cnt_q == FULL);
  assign push_ok = in_vld && !full;
  assign hit     = rd_en && (32'(rd_off) < 32'(cnt_q));

  always_comb begin
    ack_amt = '0;
    if (ack_en) ack_amt = (32'(ack_n) > 32'(cnt_q)) ? cnt_q : CW'(ack_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      cnt_q   <= '0;
      overrun <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      rptr_q  <= rptr_q + PW'(ack_amt);
      wptr_q  <= wptr_q + PW'(push_ok);
      cnt_q   <= cnt_q - ack_amt + CW'(push_ok);
      overrun <= in_vld && full;
      hit_q   <= hit;
    end
  end

  wf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wptr_q),
    .wdata (in_byte),
    .re    (rd_en),
    .raddr (rptr_q + PW'(rd_off)),
    .rdata (ram_q)
  );

  assign rd_byte = hit_q ? ram_q : 8'h00;
  assign cnt     = cnt_q;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL) else $error("receive count above depth");

  assert_ovr_only_full_R5: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(cnt_q) == FULL) else $error("overrun without full queue");

  assert_win_hit_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(cnt_q) != '0) else $error("window hit on empty queue");

endmodule

// File: rtl/wf_tx_side.sv
module wf_tx_side #(
  parameter int DEPTH = 1024,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [9:0]    wr_off,
  input  logic [7:0]    wr_byte,
  input  logic          cm_en,
  input  logic [9:0]    cm_n,
  input  logic          pop,
  output logic [7:0]    out_byte,
  output logic          out_vld,
  output logic [CW-1:0] cnt,
  output logic [PW-1:0] wptr
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q, free_sp, cm_amt;
  logic          wr_ok, pop_ok;

  assign free_sp = FULL - cnt_q;
  assign wr_ok   = wr_en && (32'(wr_off) < 32'(free_sp));
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    cm_amt = '0;
    if (cm_en) cm_amt = (32'(cm_n) > 32'(free_sp)) ? free_sp : CW'(cm_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      cnt_q   <= '0;
      out_vld <= 1'b0;
    end else begin
      rptr_q  <= rptr_q + PW'(pop_ok);
      wptr_q  <= wptr_q + PW'(cm_amt);
      cnt_q   <= cnt_q + cm_amt - CW'(pop_ok);
      out_vld <= pop_ok;
    end
  end

  wf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wptr_q + PW'(wr_off)),
    .wdata (wr_byte),
    .re    (pop_ok),
    .raddr (rptr_q),
    .rdata (out_byte)
  );

  assign cnt  = cnt_q;
  assign wptr = wptr_q;

  assert_no_overfill_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL) else $error("transmit count above depth");

  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(cnt_q) != '0) else $error("pop from empty queue");

  assert_win_room_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> cnt_q != FULL) else $error("window write into full queue");

endmodule

// File: rtl/wf_window_fifo.sv
module wf_window_fifo
  import wf_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_in_vld,
  input  logic [7:0]  rx_in_byte,
  output logic        rx_overrun,
  input  logic        tx_pop,
  output logic [7:0]  tx_data,
  output logic        tx_data_vld,
  output logic        tx_avail
);

  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [PW-1:0] tx_wptr;
  logic [9:0]    rx_c10, tx_c10;
  logic [7:0]    rx_rd_byte;
  logic          rx_win_rd, tx_win_wr, ack_en, cm_en;
  rsel_t         sel_q;
  logic [31:0]   reg_q;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata[31:10];

  assign rx_win_rd = bus_rd && (bus_addr >= A_RXWIN) && (bus_addr < A_TXWIN);
  assign tx_win_wr = bus_wr && (bus_addr[11:10] == 2'b01);
  assign ack_en    = bus_wr && (bus_addr == A_RXACK);
  assign cm_en     = bus_wr && (bus_addr == A_TXCTL);

  assign rx_c10 = fld10(32'(rx_cnt));
  assign tx_c10 = fld10(32'(tx_cnt));

  wf_rx_side #(.DEPTH(DEPTH)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (rx_in_vld),
    .in_byte (rx_in_byte),
    .overrun (rx_overrun),
    .ack_en  (ack_en),
    .ack_n   (bus_wdata[9:0]),
    .rd_en   (rx_win_rd),
    .rd_off  (10'(bus_addr - A_RXWIN)),
    .rd_byte (rx_rd_byte),
    .cnt     (rx_cnt)
  );

  wf_tx_side #(.DEPTH(DEPTH)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tx_win_wr),
    .wr_off   (bus_addr[9:0]),
    .wr_byte  (bus_wdata[7:0]),
    .cm_en    (cm_en),
    .cm_n     (bus_wdata[9:0]),
    .pop      (tx_pop),
    .out_byte (tx_data),
    .out_vld  (tx_data_vld),
    .cnt      (tx_cnt),
    .wptr     (tx_wptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_NONE;
      reg_q <= '0;
    end else begin
      sel_q <= SEL_NONE;
      if (bus_rd) begin
        if (bus_addr == A_STATUS) begin
          sel_q <= SEL_REG;
          reg_q <= {rx_c10[7:0], 16'h0000, rx_c10[9:8], 6'b000000};
        end else if (bus_addr == A_TXCTL) begin
          sel_q <= SEL_REG;
          reg_q <= {6'b000000, tx_c10, 6'b000000, 10'(tx_wptr)};
        end else if (rx_win_rd) begin
          sel_q <= SEL_RXWIN;
        end
      end
    end
  end

  always_comb begin
    case (sel_q)
      SEL_REG:   bus_rdata = reg_q;
      SEL_RXWIN: bus_rdata = {24'h000000, rx_rd_byte};
      default:   bus_rdata = '0;
    endcase
  end

  assign tx_avail = (tx_cnt != '0);

endmodule

// File: tb/tb_wf_window_fifo.sv
`timescale 1ns/1ps
module tb_wf_window_fifo;

  localparam int D = 512;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_rd, bus_wr, rx_in_vld, tx_pop;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  rx_in_byte, tx_data;
  logic        rx_overrun, tx_data_vld, tx_avail;

  always #10 clk = ~clk;

  wf_window_fifo #(.DEPTH(D)) dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_in_vld(rx_in_vld),
    .rx_in_byte(rx_in_byte), .rx_overrun(rx_overrun), .tx_pop(tx_pop),
    .tx_data(tx_data), .tx_data_vld(tx_data_vld), .tx_avail(tx_avail)
  );

  int          n_run = 0, n_fail = 0;
  logic [7:0]  rxq[$];
  logic [7:0]  txq[$];
  logic [7:0]  stage[D];
  int          txwp = 0;
  logic [31:0] exp_rdata = '0;
  logic        exp_ovr = 1'b0, exp_tvld = 1'b0;
  logic [7:0]  exp_tdata = '0;
  string       cur_tag = "R1 idle rdata";
  int          staged_n = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Behavioural queue model, applied with the inputs present at the edge.
  task automatic model();
    int rs = rxq.size();
    int ts = txq.size();
    int a  = int'(bus_addr);
    logic [9:0] c;
    exp_rdata = '0;
    if (bus_rd) begin
      if (a == 0) begin
        c = 10'(rs);
        exp_rdata = {c[7:0], 16'h0000, c[9:8], 6'b000000};
      end else if (a == 'h804) begin
        exp_rdata = {6'b0, 10'(ts), 6'b0, 10'(txwp)};
      end else if (a >= 4 && a < 'h400) begin
        exp_rdata = ((a - 4) < rs) ? {24'h0, rxq[a - 4]} : 32'h0;
      end
    end
    exp_ovr  = rx_in_vld && (rs == D);
    exp_tvld = 1'b0;
    if (tx_pop && ts > 0) begin
      exp_tvld  = 1'b1;
      exp_tdata = txq.pop_front();
    end
    if (bus_wr) begin
      if (a == 'h800) begin
        for (int i = 0; i < imin(int'(bus_wdata[9:0]), rs); i++) void'(rxq.pop_front());
      end else if (a >= 'h400 && a < 'h800) begin
        if ((a - 'h400) < D - ts) stage[a - 'h400] = bus_wdata[7:0];
      end else if (a == 'h804) begin
        int n = imin(int'(bus_wdata[9:0]), D - ts);
        for (int i = 0; i < n; i++) txq.push_back(stage[i]);
        for (int i = 0; i < D; i++) stage[i] = (i + n < D) ? stage[i + n] : 8'h00;
        txwp = (txwp + n) % D;
      end
    end
    if (rx_in_vld && rs < D) rxq.push_back(rx_in_byte);
  endtask

  task automatic clear_in();
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rx_in_vld = 0; rx_in_byte = '0; tx_pop = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(cur_tag, bus_rdata, exp_rdata);
    chk("R5 overrun pulse", {31'b0, rx_overrun}, {31'b0, exp_ovr});
    chk("R9 pop valid", {31'b0, tx_data_vld}, {31'b0, exp_tvld});
    if (exp_tvld) chk("R9 pop data", {24'b0, tx_data}, {24'b0, exp_tdata});
    chk("R9 tx_avail", {31'b0, tx_avail}, {31'b0, (txq.size() != 0)});
    cur_tag = "R1 idle rdata";
    clear_in();
  endtask

  task automatic rd(input int a, input string tag);
    bus_rd = 1; bus_addr = 12'(a); cur_tag = tag; cyc();
  endtask

  task automatic wr(input int a, input int d);
    bus_wr = 1; bus_addr = 12'(a); bus_wdata = 32'(d); cyc();
  endtask

  task automatic push(input int b);
    rx_in_vld = 1; rx_in_byte = 8'(b); cyc();
  endtask

  task automatic pop();
    tx_pop = 1; cyc();
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) stage[i] = 8'h00;
    clear_in();
    rst = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 tx_avail after reset", {31'b0, tx_avail}, 32'h0);
    chk("R1 tx_data_vld after reset", {31'b0, tx_data_vld}, 32'h0);
    chk("R1 rx_overrun after reset", {31'b0, rx_overrun}, 32'h0);
    rd('h000, "R1 status after reset");
    rd('h804, "R1 tx control after reset");

    // R2, R3: receive, status fields, window reads
    for (int i = 0; i < 5; i++) push(8'h10 + i);
    rd('h000, "R2 status count 5");
    for (int k = 0; k < 6; k++) rd('h004 + k, "R3 rx window read");

    // R4: acknowledge and clamp
    wr('h800, 2);
    rd('h004, "R4 window after ack 2");
    wr('h800, 100);
    rd('h000, "R4 status after clamped ack");

    // R2 high count fields, R5 overrun
    for (int i = 0; i < 300; i++) push(i * 7);
    rd('h000, "R2 status count 300");
    for (int i = 0; i < 212; i++) push(i + 3);
    rd('h000, "R2 status count 512");
    push(8'hAA);
    push(8'hBB);
    rx_in_vld = 1; rx_in_byte = 8'hCC; bus_wr = 1; bus_addr = 12'h800; bus_wdata = 1;
    cyc();
    rd('h004 + 510, "R3 window last byte");
    rd('h004 + 511, "R3 window beyond fill");

    // R10: receive wrap
    wr('h800, 511);
    for (int i = 0; i < 20; i++) push(8'h80 + i);
    for (int k = 0; k < 20; k++) rd('h004 + k, "R10 rx window after wrap");
    wr('h800, 20);
    rd('h000, "R10 status after wrap");

    // R6, R7, R8, R9: transmit
    for (int k = 0; k < 5; k++) wr('h400 + k, 8'h50 + k);
    rd('h804, "R8 tx control before commit");
    wr('h804, 3);
    rd('h804, "R8 tx control after commit 3");
    for (int i = 0; i < 4; i++) pop();
    wr('h804, 2);
    pop(); pop(); pop();

    // R7 clamp, R6 ignored write, R10 transmit wrap
    for (int k = 0; k < D; k++) wr('h400 + k, k ^ 8'h5A);
    wr('h804, 600);
    rd('h804, "R7 tx control after clamped commit");
    wr('h400, 8'hEE);
    pop();
    wr('h401, 8'hDD);
    wr('h400, 8'h77);
    wr('h804, 1);
    rd('h804, "R10 tx control after wrap");
    for (int i = 0; i < D + 1; i++) pop();

    // Mixed traffic
    for (int t = 0; t < 3000; t++) begin
      int op = $urandom_range(0, 7);
      rx_in_vld  = $urandom_range(0, 1);
      rx_in_byte = 8'($urandom);
      tx_pop     = ($urandom_range(0, 2) == 0);
      case (op)
        0: begin bus_rd = 1; bus_addr = 12'(4 + $urandom_range(0, 40)); cur_tag = "R3 mixed window"; end
        1: begin bus_rd = 1; bus_addr = 12'h000; cur_tag = "R2 mixed status"; end
        2: begin bus_rd = 1; bus_addr = 12'h804; cur_tag = "R8 mixed tx control"; end
        3: begin bus_wr = 1; bus_addr = 12'h800; bus_wdata = 32'($urandom_range(0, 12)); end
        4, 5: begin
          if (staged_n < D - txq.size() && staged_n < 64) begin
            bus_wr = 1; bus_addr = 12'('h400 + staged_n); bus_wdata = 32'($urandom_range(0, 255));
            staged_n++;
          end
        end
        6: begin bus_wr = 1; bus_addr = 12'h804; bus_wdata = 32'(staged_n); staged_n = 0; end
        default: ;
      endcase
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule